// File: doc/BRIEF.md
# Configuration Address Translator

This unit sits between a host's memory-mapped slave port and a downstream configuration port. The host sees two 4 KiB windows, chosen by a window-select bit. The index window holds a single 32-bit index register that can be written and read back. An access to the data window becomes one configuration read or write cycle on the downstream port. The address of that cycle comes from converting the stored index, together with the low three address bits of the data-window access, into a packed device/function/register form.

The index register supports three formats. With bit 31 set, the index passes through and only its two low bits are replaced. With bit 0 set, it is treated as a type-1 style index and its three low bits are replaced. Otherwise it is a type-0 style index, where a one-hot slot select in bits 31:11 is turned into a 5-bit device number. Data moves in little-endian byte lanes, with byte enables taken from the access size and offset.

The unit also has an interrupt swizzle. Each device's four interrupt pins are folded onto four shared interrupt outputs, according to the device number.

The sequencer has three states:
- IDLE: index accesses complete here, with no wait.
- PEND: the downstream request is held here.
- RESP: the result is returned to the host here.

The transitions are:
- IDLE to PEND on "data access accepted".
- PEND to RESP on "downstream ready".
- RESP to IDLE on "response delivered".
- All other cases stay in the current state.

Top module: `cfg_xlat_bridge`

## Requirements
- R1: A host write to the index window (bus_win = 0) completes in the cycle it is presented (bus_ready high in IDLE). The new value is returned by the next index-window read.
- R2: When index bit 31 is 1, dn_addr equals the index with bits 1:0 replaced by bus_addr[1:0].
- R3: When index bit 31 is 0 and bit 0 is 1, dn_addr equals the index with bits 2:0 replaced by bus_addr[2:0].
- R4: When index bits 31 and 0 are both 0, the index is type-0 style. dn_addr[15:11] holds the position of the lowest set bit among index bits 30:11. dn_addr[10:8] holds index[10:8], dn_addr[7:3] holds index[7:3], and dn_addr[2:0] holds bus_addr[2:0]. dn_addr[31:16] is 0.
- R5: In a type-0 style index with bits 31:11 all zero, dn_addr[31:11] are all ones. The lower fields are as in R4.
- R6: A data-window access (bus_win = 1) raises dn_req. While dn_ready is low, dn_req, dn_addr, dn_be, dn_write and dn_wdata hold their values. dn_req drops in the cycle after dn_ready is seen.
- R7: Size codes are 0 for byte, 1 for halfword, and 2 or 3 for word. Byte enables are:
  - byte: 0001 shifted left by bus_addr[1:0]
  - halfword: 0011 shifted left by 2*bus_addr[1]
  - word: 1111
- R8: Lanes are little-endian.
  - The write data's low byte, or low halfword, is placed on the lane selected by the offset. Other lanes are zero.
  - Read data is shifted down from that lane and zero-extended.
  - Words are not shifted.
- R9: A data-window read completes with bus_ready in the RESP state, carrying the aligned downstream read data. This happens one cycle after dn_ready.
- R10: irq_out[k] is high one cycle after any device pin p of device d, with (d + p) mod 4 = k, is high. The pin is dev_irq[4*d+p]. irq_out[k] is the OR of all such pins.
- R11: Reset clears the index to 0 and drives dn_req and irq_out low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Host access request, held until bus_ready |
| bus_win | input | 1 | Window select: 0 index, 1 data |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | WIN_AW | Byte offset within the window |
| bus_size | input | 2 | Access size code |
| bus_wdata | input | 32 | Host write data, right-aligned |
| bus_ready | output | 1 | Access completes at this clock edge |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| dn_req | output | 1 | Downstream configuration request |
| dn_write | output | 1 | Downstream direction |
| dn_addr | output | 32 | Translated configuration address |
| dn_be | output | 4 | Downstream byte enables |
| dn_wdata | output | 32 | Lane-placed write data |
| dn_ready | input | 1 | Downstream completion |
| dn_rdata | input | 32 | Downstream read data, 32-bit lane order |
| dev_irq | input | NDEV*4 | Device interrupt pin levels, device-major |
| irq_out | output | 4 | Swizzled interrupt outputs |

## Verification
Indexes are drawn from five families, and each family checks a different decode branch:
- pass-through
- type-1
- single slot bit
- several slot bits
- no slot bit

The several-bit family separates a lowest-bit search from a highest-bit search. The no-slot family checks the all-ones fill. Directed edges pin down the bit-11 and bit-30 slots and the zero index.

Each family is crossed with every size and offset, so a wrong lane shift or byte-enable pattern shows up. Varying the downstream latency exercises the hold behaviour. Random interrupt vectors, plus single-pin sweeps, separate correct swizzle routing from a wrong modulus or an off-by-one.

// File: rtl/cxb_pkg.sv
package cxb_pkg;
    localparam int CFG_W = 32;
    localparam int BE_W  = CFG_W / 8;
    localparam int PINS  = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_RESP = 2'd2
    } seq_state_t;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    typedef struct packed {
        logic             write;
        logic [CFG_W-1:0] addr;
        logic [1:0]       size;
        logic [1:0]       lane;
        logic [CFG_W-1:0] wdata;
    } dn_cmd_t;
endpackage

// File: rtl/cxb_xlat.sv
module cxb_xlat
    import cxb_pkg::*;
(
    input  logic [CFG_W-1:0] index,
    input  logic [2:0]       low_addr,
    output logic [CFG_W-1:0] cfg_addr
);
    localparam int SLOT_LO = 11;
    localparam int SLOT_HI = CFG_W - 1;

    logic [4:0] slot;
    logic       slot_found;

    always_comb begin
        slot       = '1;
        slot_found = 1'b0;
        for (int b = SLOT_HI; b >= SLOT_LO; b--) begin
            if (index[b]) begin
                slot       = 5'(b);
                slot_found = 1'b1;
            end
        end
    end

    always_comb begin
        if (index[CFG_W-1]) begin
            cfg_addr = {index[CFG_W-1:2], low_addr[1:0]};
        end else if (index[0]) begin
            cfg_addr = {index[CFG_W-1:3], low_addr};
        end else if (slot_found) begin
            cfg_addr = {16'h0000, slot, index[10:8], index[7:3], low_addr};
        end else begin
            cfg_addr = {{(CFG_W-SLOT_LO){1'b1}}, index[10:8], index[7:3], low_addr};
        end
    end
endmodule

// File: rtl/cxb_lanes.sv
module cxb_lanes
    import cxb_pkg::*;
(
    input  logic [1:0]       size,
    input  logic [1:0]       lane,
    input  logic [CFG_W-1:0] wdata,
    input  logic [CFG_W-1:0] rd_raw,
    output logic [BE_W-1:0]  be,
    output logic [CFG_W-1:0] wr_lane,
    output logic [CFG_W-1:0] rd_out
);
    logic [4:0]       shamt;
    logic [CFG_W-1:0] mask;

    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                be    = 4'b0001 << lane;
                shamt = {lane, 3'b000};
                mask  = 32'h0000_00FF;
            end
            SZ_HALF: begin
                be    = 4'b0011 << {lane[1], 1'b0};
                shamt = {lane[1], 4'b0000};
                mask  = 32'h0000_FFFF;
            end
            default: begin
                be    = 4'b1111;
                shamt = 5'd0;
                mask  = 32'hFFFF_FFFF;
            end
        endcase
        wr_lane = (wdata & mask) << shamt;
        rd_out  = (rd_raw >> shamt) & mask;
    end
endmodule

// File: rtl/cxb_swizzle.sv
module cxb_swizzle
    import cxb_pkg::*;
#(
    parameter int NDEV = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NDEV*PINS-1:0] dev_irq,
    output logic [PINS-1:0]    irq_out
);
    function automatic logic [NDEV*PINS-1:0] route_mask(input int k);
        logic [NDEV*PINS-1:0] m;
        m = '0;
        for (int d = 0; d < NDEV; d++) begin
            for (int p = 0; p < PINS; p++) begin
                if (((d + p) % PINS) == k) m[d*PINS+p] = 1'b1;
            end
        end
        return m;
    endfunction

    logic [PINS-1:0] hit;

    for (genvar k = 0; k < PINS; k++) begin : g_route
        localparam logic [NDEV*PINS-1:0] MASK = route_mask(k);
        assign hit[k] = |(dev_irq & MASK);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= '0;
        else        irq_out <= hit;
    end

    assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_irq == '0) |=> (irq_out == '0));
endmodule

// File: rtl/cfg_xlat_bridge.sv
module cfg_xlat_bridge
    import cxb_pkg::*;
#(
    parameter int NDEV   = 32,
    parameter int WIN_AW = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_valid,
    input  logic                  bus_win,
    input  logic                  bus_write,
    input  logic [WIN_AW-1:0]     bus_addr,
    input  logic [1:0]            bus_size,
    input  logic [CFG_W-1:0]      bus_wdata,
    output logic                  bus_ready,
    output logic [CFG_W-1:0]      bus_rdata,
    output logic                  dn_req,
    output logic                  dn_write,
    output logic [CFG_W-1:0]      dn_addr,
    output logic [BE_W-1:0]       dn_be,
    output logic [CFG_W-1:0]      dn_wdata,
    input  logic                  dn_ready,
    input  logic [CFG_W-1:0]      dn_rdata,
    input  logic [NDEV*PINS-1:0]  dev_irq,
    output logic [PINS-1:0]       irq_out
);
    seq_state_t       st_q, st_d;
    logic [CFG_W-1:0] idx_q;
    dn_cmd_t          cmd_q;
    logic [CFG_W-1:0] rd_q;
    logic [CFG_W-1:0] xl_addr;
    logic [CFG_W-1:0] rd_aligned;

    cxb_xlat u_xlat (
        .index    (idx_q),
        .low_addr (bus_addr[2:0]),
        .cfg_addr (xl_addr)
    );

    cxb_lanes u_lanes (
        .size    (cmd_q.size),
        .lane    (cmd_q.lane),
        .wdata   (cmd_q.wdata),
        .rd_raw  (dn_rdata),
        .be      (dn_be),
        .wr_lane (dn_wdata),
        .rd_out  (rd_aligned)
    );

    cxb_swizzle #(.NDEV(NDEV)) u_swz (
        .clk     (clk),
        .rst_n   (rst_n),
        .dev_irq (dev_irq),
        .irq_out (irq_out)
    );

    // next-state decision
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (bus_valid && bus_win) st_d = ST_PEND;
            ST_PEND: if (dn_ready)             st_d = ST_RESP;
            ST_RESP:                           st_d = ST_IDLE;
            default:                           st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            cmd_q <= '0;
            rd_q  <= '0;
        end else begin
            if (st_q == ST_IDLE && bus_valid) begin
                if (!bus_win) begin
                    if (bus_write) idx_q <= bus_wdata;
                end else begin
                    cmd_q.write <= bus_write;
                    cmd_q.addr  <= xl_addr;
                    cmd_q.size  <= bus_size;
                    cmd_q.lane  <= bus_addr[1:0];
                    cmd_q.wdata <= bus_wdata;
                end
            end
            if (st_q == ST_PEND && dn_ready) rd_q <= rd_aligned;
        end
    end

    // outputs
    always_comb begin
        bus_ready = 1'b0;
        bus_rdata = '0;
        dn_req    = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (bus_valid && !bus_win) begin
                    bus_ready = 1'b1;
                    bus_rdata = idx_q;
                end
            end
            ST_PEND: dn_req = 1'b1;
            ST_RESP: begin
                bus_ready = 1'b1;
                bus_rdata = rd_q;
            end
            default: ;
        endcase
    end

    assign dn_write = cmd_q.write;
    assign dn_addr  = cmd_q.addr;

    assert_idx_wr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_win && bus_write && bus_ready) |=> (idx_q == $past(bus_wdata)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && !dn_ready) |=> (dn_req && $stable(dn_addr) && $stable(dn_be)
                                   && $stable(dn_wdata) && $stable(dn_write)));

    assert_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && dn_ready) |=> !dn_req);

    assert_byte_be_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && cmd_q.size == SZ_BYTE) |-> $onehot(dn_be));

    assert_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && dn_ready) |=> bus_ready);
endmodule

// File: tb/cfg_xlat_bridge_test.sv
`timescale 1ns/1ps
module cfg_xlat_bridge_test;
    localparam int NDEV = 32;
    localparam int AW   = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0, bus_win = 1'b0, bus_write = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic [1:0]        bus_size = '0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_ready;
    logic [31:0]       bus_rdata;
    logic              dn_req, dn_write;
    logic [31:0]       dn_addr, dn_wdata;
    logic [3:0]        dn_be;
    logic              dn_ready = 1'b0;
    logic [31:0]       dn_rdata = '0;
    logic [NDEV*4-1:0] dev_irq = '0;
    logic [3:0]        irq_out;

    int checks = 0;
    int fails  = 0;

    logic [31:0] seen_addr, seen_wdata;
    logic [3:0]  seen_be;
    logic        seen_wr;
    int          seen_cnt = 0;
    int          lat = 0;

    always #2 clk = ~clk;

    cfg_xlat_bridge #(.NDEV(NDEV), .WIN_AW(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_win(bus_win), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .dn_req(dn_req), .dn_write(dn_write), .dn_addr(dn_addr), .dn_be(dn_be),
        .dn_wdata(dn_wdata), .dn_ready(dn_ready), .dn_rdata(dn_rdata),
        .dev_irq(dev_irq), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rsp_val(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, a[31:16] ^ 16'h0F0F};
    endfunction

    function automatic logic [31:0] ref_addr(input logic [31:0] idx, input logic [2:0] a);
        logic [4:0] slot;
        logic       found;
        if (idx[31]) return {idx[31:2], a[1:0]};
        if (idx[0])  return {idx[31:3], a};
        found = 1'b0;
        slot  = 5'd0;
        for (int i = 11; i <= 31; i++) begin
            if (!found && idx[i]) begin
                slot  = 5'(i);
                found = 1'b1;
            end
        end
        if (!found) return {21'h1FFFFF, idx[10:8], idx[7:3], a};
        return {16'h0, slot, idx[10:8], idx[7:3], a};
    endfunction

    function automatic logic [3:0] ref_be(input logic [1:0] sz, input logic [1:0] ln);
        if (sz == 2'd0) return 4'b0001 << ln;
        if (sz == 2'd1) return 4'b0011 << {ln[1], 1'b0};
        return 4'hF;
    endfunction

    function automatic int ref_shift(input logic [1:0] sz, input logic [1:0] ln);
        if (sz == 2'd0) return 8 * ln;
        if (sz == 2'd1) return 16 * ln[1];
        return 0;
    endfunction

    function automatic logic [31:0] ref_mask(input logic [1:0] sz);
        if (sz == 2'd0) return 32'hFF;
        if (sz == 2'd1) return 32'hFFFF;
        return 32'hFFFF_FFFF;
    endfunction

    function automatic logic [3:0] ref_irq(input logic [NDEV*4-1:0] v);
        logic [3:0] o = '0;
        for (int d = 0; d < NDEV; d++)
            for (int p = 0; p < 4; p++)
                if (v[d*4+p]) o[(d+p)%4] = 1'b1;
        return o;
    endfunction

    // downstream responder with random latency
    initial begin
        forever begin
            @(negedge clk);
            if (dn_ready) begin
                dn_ready = 1'b0;
            end else if (dn_req) begin
                if (lat == 0) begin
                    seen_addr  = dn_addr;
                    seen_be    = dn_be;
                    seen_wdata = dn_wdata;
                    seen_wr    = dn_write;
                    seen_cnt++;
                    dn_rdata   = rsp_val(dn_addr);
                    dn_ready   = 1'b1;
                    lat        = $urandom % 4;
                end else begin
                    lat--;
                end
            end
        end
    end

    task automatic bus_xfer(input logic win, input logic wr, input logic [AW-1:0] a,
                            input logic [1:0] sz, input logic [31:0] wd,
                            output logic [31:0] rd);
        @(negedge clk);
        bus_valid = 1'b1; bus_win = win; bus_write = wr;
        bus_addr = a; bus_size = sz; bus_wdata = wd;
        forever begin
            #1;
            if (bus_ready) begin
                rd = bus_rdata;
                @(posedge clk);
                @(negedge clk);
                bus_valid = 1'b0;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic set_index(input logic [31:0] v);
        logic [31:0] rd;
        bus_xfer(1'b0, 1'b1, 12'h000, 2'd2, v, rd);
    endtask

    task automatic data_access(input logic [31:0] idx, input logic wr,
                               input logic [AW-1:0] a, input logic [1:0] sz);
        logic [31:0] rd, wd, ea;
        int sh;
        wd = $urandom;
        bus_xfer(1'b1, wr, a, sz, wd, rd);
        ea = ref_addr(idx, a[2:0]);
        sh = ref_shift(sz, a[1:0]);
        if (idx[31])      check("R2 pass-through addr", seen_addr, ea);
        else if (idx[0])  check("R3 type-1 addr", seen_addr, ea);
        else if (idx[31:11] == 0) check("R5 empty-slot addr", seen_addr, ea);
        else              check("R4 type-0 addr", seen_addr, ea);
        check("R7 byte enables", {28'h0, seen_be}, {28'h0, ref_be(sz, a[1:0])});
        check("R6 direction", {31'h0, seen_wr}, {31'h0, wr});
        if (wr) check("R8 write lanes", seen_wdata, (wd & ref_mask(sz)) << sh);
        else    check("R9 R8 read data", rd, (rsp_val(ea) >> sh) & ref_mask(sz));
    endtask

    function automatic logic [31:0] gen_idx(input int kind);
        unique case (kind)
            0: return $urandom | 32'h8000_0000;
            1: return ($urandom & 32'h7FFF_FFFF) | 32'h1;
            2: return (32'h1 << (11 + $urandom % 20)) | ($urandom & 32'h7FE);
            3: return $urandom & 32'h7FE;
            default: return ($urandom & 32'h7FFF_F800) | ($urandom & 32'h7FE);
        endcase
    endfunction

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] idx;
        logic [31:0] dir_idx [7];
        void'($urandom(32'd20240611));
        dir_idx = '{32'h8000_0000, 32'h0000_0001, 32'h4000_0000, 32'h0000_0800,
                    32'h0000_0000, 32'h7FFF_F800, 32'h0000_07FE};

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        check("R11 irq_out after reset", {28'h0, irq_out}, 32'h0);
        check("R11 dn_req after reset", {31'h0, dn_req}, 32'h0);
        bus_xfer(1'b0, 1'b0, 12'h000, 2'd2, 32'h0, rd);
        check("R11 index after reset", rd, 32'h0);

        // R1 index write / read back
        set_index(32'hDEAD_BEEF);
        bus_xfer(1'b0, 1'b0, 12'h004, 2'd2, 32'h0, rd);
        check("R1 index readback", rd, 32'hDEAD_BEEF);

        // directed index corners across sizes and offsets
        foreach (dir_idx[i]) begin
            set_index(dir_idx[i]);
            for (int o = 0; o < 8; o++) begin
                data_access(dir_idx[i], o[0], AW'(o), 2'(o % 3));
            end
        end

        // random mix
        for (int n = 0; n < 300; n++) begin
            idx = gen_idx(n % 5);
            set_index(idx);
            bus_xfer(1'b0, 1'b0, 12'h000, 2'd2, 32'h0, rd);
            check("R1 random index readback", rd, idx);
            data_access(idx, 1'($urandom), AW'($urandom), 2'($urandom));
        end

        // R10 interrupt swizzle: single-pin sweep then random vectors
        for (int b = 0; b < NDEV * 4; b += 5) begin
            @(negedge clk);
            dev_irq = '0;
            dev_irq[b] = 1'b1;
            @(posedge clk);
            @(negedge clk);
            check("R10 single pin route", {28'h0, irq_out}, {28'h0, ref_irq(dev_irq)});
        end
        for (int n = 0; n < 40; n++) begin
            @(negedge clk);
            for (int w = 0; w < NDEV * 4; w++)
                dev_irq[w] = (($urandom % 16) == 0);
            @(posedge clk);
            @(negedge clk);
            check("R10 random vector", {28'h0, irq_out}, {28'h0, ref_irq(dev_irq)});
        end
        @(negedge clk);
        dev_irq = '0;
        @(posedge clk);
        @(negedge clk);
        check("R10 all quiet", {28'h0, irq_out}, 32'h0);

        // R11 reset mid-life clears index
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        bus_xfer(1'b0, 1'b0, 12'h000, 2'd2, 32'h0, rd);
        check("R11 index cleared by reset", rd, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule